// File: doc/BRIEF.md
# Key-Guarded Configuration Write Permit

This block is a single 32-bit register on a simple register bus. It decides whether the protected configuration registers of one or more pin banks, such as their direction mode registers, may be written. Software opens the gate by writing an exact 16-bit magic value into the low half-word of the register. It closes the gate by writing zero there. Any other key value has no effect on the state.

The current state shows up in two places. Bit 31 of the register reads back as the state, and a registered permit output carries it to every bank, so one gate covers the protected registers of all banks. The register occupies an 8-byte window. The word at offset 0 is live. The word at offset 4 reads as zero and ignores writes.

Top module: `cfg_key_lock`

## Requirements
- R1: After reset the lock is inactive: `permitOut` is 0 and a read of offset 0 returns 0x00000000.
- R2: A write to offset 0 whose bits [15:0] equal 0xD42F activates the lock. From the cycle after the write, bit 31 of the offset-0 read data is 1.
- R3: A write to offset 0 whose bits [15:0] equal 0x0000 deactivates the lock. From the cycle after the write, bit 31 reads 0.
- R4: A write to offset 0 with any other key value leaves the lock state unchanged, whether the lock is active or inactive.
- R5: Read data of offset 0 is {state, 15'b0, key}, where key is 0xD42F while active and 0x0000 while inactive. Bits [30:16] always read 0, and write data in bits [31:16] has no effect.
- R6: `permitOut` is a registered copy of the state. It equals bit 31 of the offset-0 read data in every cycle and never follows write data combinationally.
- R7: Reads of offset 4 return 0x00000000, and writes to offset 4 leave the lock state unchanged.
- R8: `permitOut` has one bit per bank (parameter NUM_BANKS). All bits always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 3 | Byte offset inside the 8-byte window |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| permitOut | output | NUM_BANKS | Write permit, one bit per bank |

## Verification
The state register is updated on the clock edge that samples a write. The new state therefore appears on `busRdData` and `permitOut` in the cycle after that edge, not in the write cycle itself. Read data depends combinationally on the address, so a read shows the result in the same cycle the address is presented. The bench drives inputs on the falling edge and checks one full cycle after each write, which places every check after the state register has been updated. It also samples `permitOut` during the write cycle, before the edge, to confirm that the output does not respond to the write data early.

// File: rtl/cfg_key_lock_pkg.sv
package cfg_key_lock_pkg;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 16;
  localparam int ADDR_W = 3;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hD42F;
  localparam logic [KEY_W-1:0] KEY_CLOSE = 16'h0000;

  typedef struct packed {
    logic setLock;
    logic clrLock;
  } lockCmd_t;
endpackage

// File: rtl/cfg_key_lock_ctrl.sv
module cfg_key_lock_ctrl
  import cfg_key_lock_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [KEY_W-1:0]  keyIn,
  output lockCmd_t          cmd
);
  logic hitPrimary;

  always_comb begin
    hitPrimary  = (busAddr[ADDR_W-1:2] == '0);
    cmd.setLock = busWrEn && hitPrimary && (keyIn == KEY_OPEN);
    cmd.clrLock = busWrEn && hitPrimary && (keyIn == KEY_CLOSE);
  end
endmodule

// File: rtl/cfg_key_lock_dp.sv
module cfg_key_lock_dp
  import cfg_key_lock_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lockCmd_t             cmd,
  input  logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busRdData,
  output logic [NUM_BANKS-1:0] permitOut
);
  logic lockActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lockActive <= 1'b0;
    else if (cmd.setLock) lockActive <= 1'b1;
    else if (cmd.clrLock) lockActive <= 1'b0;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr[ADDR_W-1:2] == '0) begin
      busRdData[DATA_W-1]  = lockActive;
      busRdData[KEY_W-1:0] = lockActive ? KEY_OPEN : KEY_CLOSE;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_permit
    assign permitOut[b] = lockActive;
  end
endmodule

// File: rtl/cfg_key_lock.sv
module cfg_key_lock
  import cfg_key_lock_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [2:0]           busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic [NUM_BANKS-1:0] permitOut
);
  lockCmd_t cmd;
  logic [DATA_W-KEY_W-1:0] unusedHi;

  assign unusedHi = busWrData[DATA_W-1:KEY_W];

  cfg_key_lock_ctrl i_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .keyIn   (busWrData[KEY_W-1:0]),
    .cmd     (cmd)
  );

  cfg_key_lock_dp #(.NUM_BANKS(NUM_BANKS)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .busAddr   (busAddr),
    .busRdData (busRdData),
    .permitOut (permitOut)
  );
endmodule

// File: rtl/cfg_key_lock_chk.sv
module cfg_key_lock_chk #(
  parameter int NUM_BANKS = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWrEn,
  input logic [2:0]           busAddr,
  input logic [31:0]          busWrData,
  input logic [31:0]          busRdData,
  input logic [NUM_BANKS-1:0] permitOut
);
  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[2] == 1'b0 && busWrData[15:0] == 16'hD42F) |=> permitOut[0]);

  // R3
  key_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[2] == 1'b0 && busWrData[15:0] == 16'h0000) |=> !permitOut[0]);

  // R4
  bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[2] == 1'b0 && busWrData[15:0] != 16'hD42F
      && busWrData[15:0] != 16'h0000) |=> $stable(permitOut));

  // R7
  upper_word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[2] == 1'b1) |=> $stable(permitOut));

  // R7
  upper_word_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[2] == 1'b1) |-> busRdData == 32'h0);

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[30:16] == 15'h0);

  // R6
  permit_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[2] == 1'b0) |-> busRdData[31] == permitOut[0]);

  // R8
  banks_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (permitOut == '0) || (permitOut == '1));

  // R6
  no_idle_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(permitOut));
endmodule

bind cfg_key_lock cfg_key_lock_chk #(.NUM_BANKS(NUM_BANKS)) i_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .permitOut(permitOut)
);

// File: tb/test_cfg_key_lock.sv
module test_cfg_key_lock;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic [NB-1:0] permitOut;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_key_lock #(.NUM_BANKS(NB)) i_cfg_key_lock (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .permitOut(permitOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 3'd0; busWrData = 32'h0;
  endtask

  task automatic expectState(input string req, input bit st);
    busAddr = 3'd0;
    #1;
    check(req, busRdData, st ? 32'h8000D42F : 32'h0);
    check(req, {29'b0, permitOut}, st ? {29'b0, {NB{1'b1}}} : 32'h0);
  endtask

  task automatic testReset();
    expectState("R1", 1'b0);
  endtask

  task automatic testOpen();
    // R6: permit must not follow write data within the write cycle
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 3'd0; busWrData = 32'h0000D42F;
    #1;
    check("R6", {29'b0, permitOut}, 32'h0);
    @(negedge clk);
    busWrEn = 1'b0; busWrData = 32'h0;
    expectState("R2", 1'b1);
    expectState("R8", 1'b1);
  endtask

  task automatic testBadKeys();
    write(3'd0, 32'h0000D42E);
    expectState("R4", 1'b1);
    write(3'd0, 32'hFFFF1234);
    expectState("R4", 1'b1);
    write(3'd0, 32'h0);
    expectState("R3", 1'b0);
    write(3'd0, 32'h0000D430);
    expectState("R4", 1'b0);
    write(3'd0, 32'h00002FD4);
    expectState("R4", 1'b0);
  endtask

  task automatic testUpperBits();
    write(3'd0, 32'hFFFFD42F);
    expectState("R5", 1'b1);
    write(3'd0, 32'hABCD0000);
    expectState("R5", 1'b0);
  endtask

  task automatic testUpperWord();
    write(3'd4, 32'h0000D42F);
    expectState("R7", 1'b0);
    busAddr = 3'd4; #1;
    check("R7", busRdData, 32'h0);
    write(3'd0, 32'h0000D42F);
    write(3'd4, 32'h00000000);
    expectState("R7", 1'b1);
    busAddr = 3'd4; #1;
    check("R7", busRdData, 32'h0);
    write(3'd0, 32'h0);
    expectState("R3", 1'b0);
  endtask

  initial begin
    #1;
    check("R1", {29'b0, permitOut}, 32'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOpen();
    testBadKeys();
    testUpperBits();
    testUpperWord();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule